// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block sits between a processor pipeline and a slow word-wide RAM. The processor presents a 24-bit physical byte address with a read or a byte-masked write. When the addressed line is present, the access completes in the same cycle with no stall. On a miss the block raises a stall toward the pipeline. It then picks a victim way in the selected set. A dirty victim is first copied back to RAM as a burst. After that the missing line is fetched as a burst, and the held access finishes as a hit.

The geometry is set by three parameters. `Z_EXP` gives 2^z ways per set and `J_EXP` gives 2^j 32-bit words per line; both must be at least 1. `CAP_LOG2` is the total capacity in bytes, as a power of two. The tag is `PA[23:CAP_LOG2-z]`, so a full 256 KB build (`CAP_LOG2=18`) uses tag `PA[23:18-z]`. The set index is `PA[CAP_LOG2-z-1:2+j]` and the word offset is `PA[1+j:2]`. Each line carries a valid flag, a dirty flag and a tag. Replacement order inside a set is least recently used.

The RAM side uses a request/ready handshake. `mem_req` stays high for a whole burst, with a line-aligned base address and a fixed length of 2^j words. The RAM returns or accepts one word per `mem_ready` pulse, in ascending address order.

Top module: `wb_cache_top`

## Requirements
- R1: Address split: tag `PA[23:CAP_LOG2-Z_EXP]`, set index `PA[CAP_LOG2-Z_EXP-1:2+J_EXP]`, word `PA[1+J_EXP:2]`. Up to 2^z lines with equal index and different tags are held at once, and at most one way of a set matches an address.
- R2: An access hits when a way of the selected set is valid and its tag equals the address tag. A hit raises no stall in its request cycle, and a read hit returns the addressed word on `cpu_rdata` in that cycle.
- R3: A write hit updates only the bytes whose `cpu_be` bit is set (bit i selects bits 8i+7:8i) and marks the line dirty.
- R4: Reset clears every valid flag, so the first access to any line after reset misses.
- R5: A miss raises `cpu_stall` in its request cycle and keeps it high while bursts run, for at least 3 cycles per transferred word. In the cycle after the fill the stall drops and the held access completes as a hit with the fetched data.
- R6: A fill reads 2^j words in ascending order from the line-aligned base address `{tag, index, 0}`, with `mem_we` low. The filled line becomes valid and clean. `mem_len` always reads 2^j.
- R7: A dirty victim is written back as a burst of 2^j words (`mem_we` high) to its own line base, before the fill. A clean or invalid victim causes no write burst.
- R8: The victim is the lowest-numbered invalid way of the set. If all ways are valid, the victim is the least recently used way, where every hit and every completed miss counts as a use.
- R9: During a burst, `mem_req` stays high, the base address stays fixed, and exactly one word moves per `mem_ready` pulse. Outside a burst `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access valid, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Physical byte address |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when request high and stall low |
| cpu_stall | output | 1 | Hold the pipeline |
| mem_req | output | 1 | Burst in progress |
| mem_we | output | 1 | Burst direction, 1 = write-back |
| mem_addr | output | 24 | Line-aligned burst base byte address |
| mem_len | output | J_EXP+1 | Burst length in words (2^j) |
| mem_wdata | output | 32 | Write-back word for the current beat |
| mem_rdata | input | 32 | Fill word, taken when mem_ready is high |
| mem_ready | input | 1 | One word transferred this cycle |

## Verification
Two updates can land in the same cycle. One is the install of a freshly fetched line as valid and clean. The other is the completion of the held access, which may be a store that must leave the line dirty, and which also bumps the line to most recent in the age order. The bench provokes this with a store that misses. It then forces that line to become the oldest victim and checks that a write burst of 2^j words occurs. A later refill of the same address must return the stored data from RAM.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  localparam int PA_W   = 24;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/wb_cache_lru.sv
module wb_cache_lru #(
  parameter int WAY_W = 1,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch_en,
  input  logic [IDX_W-1:0]      touch_set,
  input  logic [WAY_W-1:0]      touch_way,
  input  logic [IDX_W-1:0]      look_set,
  input  logic [(1<<WAY_W)-1:0] look_valid,
  output logic [WAY_W-1:0]      victim_way
);
  localparam int WAYS = 1 << WAY_W;
  localparam int SETS = 1 << IDX_W;

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < touched_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!look_valid[w] && !found) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[look_set][w] == WAY_W'(WAYS - 1))
          victim_way = WAY_W'(w);
    end
  end

  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++)
      age_seen[age_q[look_set][w]] = 1'b1;
  end

  // R8: ages inside a set always form a permutation, so one oldest way exists
  assert_lru_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    age_seen == {WAYS{1'b1}});
endmodule

// File: rtl/wb_cache_burst_fsm.sv
module wb_cache_burst_fsm
  import wb_cache_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_start,
  input  logic              victim_dirty,
  input  logic              mem_ready,
  output cache_state_e      state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              fill_done
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  cache_state_e      state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              busy;

  assign busy = (state_q == ST_WBACK) || (state_q == ST_FILL);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (miss_start) state_d = victim_dirty ? ST_WBACK : ST_FILL;
      end
      ST_WBACK: begin
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign state_o   = state_q;
  assign beat_o    = beat_q;
  assign fill_done = (state_q == ST_FILL) && mem_ready && (beat_q == LAST_BEAT);

  // R9: the beat pointer only moves on a ready pulse while a burst runs
  assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> $stable(beat_q));

  // R7: a finished write-back always hands over to a fill of the same miss
  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK && mem_ready && beat_q == LAST_BEAT) |=> (state_q == ST_FILL && beat_q == '0));
endmodule

// File: rtl/wb_cache_top.sv
module wb_cache_top
  import wb_cache_pkg::*;
#(
  parameter int Z_EXP    = 1,
  parameter int J_EXP    = 2,
  parameter int CAP_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [23:0]       cpu_addr,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [23:0]       mem_addr,
  output logic [J_EXP:0]    mem_len,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready
);
  localparam int WAYS   = 1 << Z_EXP;
  localparam int WPL    = 1 << J_EXP;
  localparam int OFF_W  = 2 + J_EXP;
  localparam int TAG_LO = CAP_LOG2 - Z_EXP;
  localparam int TAG_W  = PA_W - TAG_LO;
  localparam int IDX_W  = TAG_LO - OFF_W;
  localparam int SETS   = 1 << IDX_W;

  // line state and storage
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WORD_W-1:0] data_q  [SETS][WAYS][WPL];

  // address decode
  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [J_EXP-1:0] a_word;
  assign a_tag  = cpu_addr[PA_W-1:TAG_LO];
  assign a_idx  = cpu_addr[TAG_LO-1:OFF_W];
  assign a_word = cpu_addr[OFF_W-1:2];

  // parallel tag compare, one comparator per way
  logic [WAYS-1:0]  way_hit;
  logic             hit;
  logic [Z_EXP-1:0] hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_q[a_idx][w] && (tag_q[a_idx][w] == a_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_way = Z_EXP'(w);
  end
  assign hit = |way_hit;

  // controller
  cache_state_e     state;
  logic [J_EXP-1:0] beat;
  logic             fill_done;
  logic             st_idle, st_resp, st_wb, st_fill;
  logic             serve, miss_start, victim_dirty;
  logic [Z_EXP-1:0] victim_way;

  assign st_idle = (state == ST_IDLE);
  assign st_resp = (state == ST_RESP);
  assign st_wb   = (state == ST_WBACK);
  assign st_fill = (state == ST_FILL);

  assign serve      = cpu_req && hit && (st_idle || st_resp);
  assign miss_start = cpu_req && !hit && st_idle;
  assign victim_dirty = valid_q[a_idx][victim_way] && dirty_q[a_idx][victim_way];

  wb_cache_burst_fsm #(.BEAT_W(J_EXP)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_start   (miss_start),
    .victim_dirty (victim_dirty),
    .mem_ready    (mem_ready),
    .state_o      (state),
    .beat_o       (beat),
    .fill_done    (fill_done)
  );

  wb_cache_lru #(.WAY_W(Z_EXP), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (serve),
    .touch_set  (a_idx),
    .touch_way  (hit_way),
    .look_set   (a_idx),
    .look_valid (valid_q[a_idx]),
    .victim_way (victim_way)
  );

  // miss context, captured when the miss is accepted
  logic [IDX_W-1:0] m_idx_q;
  logic [TAG_W-1:0] m_tag_q;
  logic [Z_EXP-1:0] m_way_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx_q <= '0;
      m_tag_q <= '0;
      m_way_q <= '0;
    end else if (miss_start) begin
      m_idx_q <= a_idx;
      m_tag_q <= a_tag;
      m_way_q <= victim_way;
    end
  end

  // flags: reset clears valid; fill installs clean; store hit marks dirty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_done) begin
        valid_q[m_idx_q][m_way_q] <= 1'b1;
        dirty_q[m_idx_q][m_way_q] <= 1'b0;
      end
      if (serve && cpu_we)
        dirty_q[a_idx][hit_way] <= 1'b1;
    end
  end

  // tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (fill_done)
      tag_q[m_idx_q][m_way_q] <= m_tag_q;
  end

  always_ff @(posedge clk) begin
    if (st_fill && mem_ready)
      data_q[m_idx_q][m_way_q][beat] <= mem_rdata;
    else if (serve && cpu_we) begin
      for (int b = 0; b < BE_W; b++)
        if (cpu_be[b])
          data_q[a_idx][hit_way][a_word][8*b +: 8] <= cpu_wdata[8*b +: 8];
    end
  end

  // processor side
  assign cpu_rdata = data_q[a_idx][hit_way][a_word];
  assign cpu_stall = (cpu_req && !hit && st_idle) || st_wb || st_fill;

  // RAM side
  assign mem_req   = st_wb || st_fill;
  assign mem_we    = st_wb;
  assign mem_len   = (J_EXP+1)'(WPL);
  assign mem_wdata = data_q[m_idx_q][m_way_q][beat];
  assign mem_addr  = st_wb ? {tag_q[m_idx_q][m_way_q], m_idx_q, {OFF_W{1'b0}}}
                           : {m_tag_q, m_idx_q, {OFF_W{1'b0}}};

  // checker state for the store-marks-dirty property
  logic             chk_wr_q;
  logic [IDX_W-1:0] chk_idx_q;
  logic [Z_EXP-1:0] chk_way_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_wr_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_way_q <= '0;
    end else begin
      chk_wr_q  <= serve && cpu_we;
      chk_idx_q <= a_idx;
      chk_way_q <= hit_way;
    end
  end

  // R3: a store hit leaves its line dirty
  assert_wr_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr_q |-> dirty_q[chk_idx_q][chk_way_q]);

  // R1: a set never holds the same tag in two valid ways
  assert_one_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> $onehot0(way_hit));

  // R5: the held access completes as an unstalled hit right after the fill
  assert_resp_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_resp && cpu_req) |-> (hit && !cpu_stall));

  // R6: a fetched line appears valid and clean before the held access acts
  assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_resp |-> (valid_q[m_idx_q][m_way_q] && !dirty_q[m_idx_q][m_way_q]));

  // R9: the burst base address does not move between beats
  assert_base_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && $past(mem_req) && mem_we == $past(mem_we)) |-> $stable(mem_addr));
endmodule

// File: tb/wb_cache_top_tb_top.sv
module wb_cache_top_tb_top;
  localparam int Z_EXP    = 1;
  localparam int J_EXP    = 2;
  localparam int CAP_LOG2 = 9;
  localparam int WPL      = 1 << J_EXP;
  localparam int RAMW     = 1024;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [23:0] cpu_addr;
  logic [3:0]  cpu_be;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ready;
  logic [23:0] mem_addr;
  logic [J_EXP:0] mem_len;
  logic [31:0] mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;

  wb_cache_top #(.Z_EXP(Z_EXP), .J_EXP(J_EXP), .CAP_LOG2(CAP_LOG2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // slow RAM model: 3 cycles per word, ascending beats from the base
  logic [31:0] ram  [RAMW];
  logic [31:0] gold [RAMW];
  int wc, pos, wb_words, bad_align;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc <= 0; pos <= 0; mem_ready <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ready) begin
      if (wc == 2) begin
        wc <= 0;
        mem_ready <= 1'b1;
        if (mem_addr[J_EXP+1:0] != '0) bad_align <= bad_align + 1;
        if (mem_we) begin
          ram[mem_addr[11:2] + 10'(pos)] <= mem_wdata;
          wb_words <= wb_words + 1;
        end else begin
          mem_rdata <= ram[mem_addr[11:2] + 10'(pos)];
        end
        pos <= (pos == WPL-1) ? 0 : pos + 1;
      end else begin
        wc <= wc + 1;
      end
    end else begin
      mem_ready <= 1'b0;
      if (!mem_req) begin wc <= 0; pos <= 0; end
    end
  end

  typedef struct packed {
    logic        we;
    logic [23:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        miss;
    logic        wb;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{1'b0, 24'h000000, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b0, 24'h000004, 4'hF, 32'h0,         1'b0, 1'b0},
    '{1'b1, 24'h000008, 4'hF, 32'hCAFE0001, 1'b0, 1'b0},
    '{1'b0, 24'h000100, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b0, 24'h00000C, 4'hF, 32'h0,         1'b0, 1'b0},
    '{1'b0, 24'h000200, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b0, 24'h000300, 4'hF, 32'h0,         1'b1, 1'b1},
    '{1'b0, 24'h000008, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b1, 24'h00030C, 4'h3, 32'h1234BEEF, 1'b0, 1'b0},
    '{1'b0, 24'h00030C, 4'hF, 32'h0,         1'b0, 1'b0},
    '{1'b0, 24'h000010, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b1, 24'h000014, 4'h8, 32'h77000000, 1'b0, 1'b0},
    '{1'b0, 24'h000100, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b0, 24'h00020C, 4'hF, 32'h0,         1'b1, 1'b1},
    '{1'b0, 24'h00030C, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b1, 24'h000404, 4'hF, 32'hD00DF00D, 1'b1, 1'b0},
    '{1'b0, 24'h000500, 4'hF, 32'h0,         1'b1, 1'b0},
    '{1'b0, 24'h000600, 4'hF, 32'h0,         1'b1, 1'b1},
    '{1'b0, 24'h000404, 4'hF, 32'h0,         1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic we, input logic [23:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic saw_miss,
                        output logic [31:0] rd, output int wbw, output int scyc);
    int start_wb;
    start_wb = wb_words;
    scyc = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
    #1;
    saw_miss = cpu_stall;
    while (cpu_stall) begin
      scyc++;
      @(negedge clk); #1;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    wbw = wb_words - start_wb;
    if (we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) gold[addr[11:2]][8*b +: 8] = wd[8*b +: 8];
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic        m;
    logic [31:0] rd;
    int          wbw, scyc;
    wb_words = 0; bad_align = 0;
    for (int i = 0; i < RAMW; i++) begin
      ram[i]  = 32'h5A000000 ^ (i * 32'h00010203);
      gold[i] = 32'h5A000000 ^ (i * 32'h00010203);
    end
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    @(negedge clk);
    check(cpu_stall == 1'b0, "R4", "stall after reset", 32'(cpu_stall), 32'h0);
    check(mem_req == 1'b0, "R9", "mem_req idle after reset", 32'(mem_req), 32'h0);
    check(mem_len == (J_EXP+1)'(WPL), "R6", "burst length", 32'(mem_len), 32'(WPL));

    // table walk: hits, misses, LRU victims, write-backs, partial stores
    for (int v = 0; v < NV; v++) begin
      do_acc(VT[v].we, VT[v].addr, VT[v].be, VT[v].wd, m, rd, wbw, scyc);
      check(m == VT[v].miss, "R2 R8", $sformatf("vec %0d miss flag", v), 32'(m), 32'(VT[v].miss));
      check(wbw == (VT[v].wb ? WPL : 0), "R7", $sformatf("vec %0d write-back words", v),
            32'(wbw), VT[v].wb ? 32'(WPL) : 32'h0);
      if (!VT[v].we)
        check(rd == gold[VT[v].addr[11:2]], "R3 R6", $sformatf("vec %0d read data", v),
              rd, gold[VT[v].addr[11:2]]);
      if (VT[v].miss)
        check(scyc >= 3*WPL*(VT[v].wb ? 2 : 1), "R5", $sformatf("vec %0d stall cycles", v),
              32'(scyc), 32'(3*WPL*(VT[v].wb ? 2 : 1)));
    end

    check(bad_align == 0, "R9", "unaligned burst beats", 32'(bad_align), 32'h0);

    // reset mid-run: the previously present line must miss again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_acc(1'b0, 24'h000400, 4'hF, 32'h0, m, rd, wbw, scyc);
    check(m == 1'b1, "R4", "line present before reset misses", 32'(m), 32'h1);
    check(rd == gold[10'h100], "R4", "refetched data after reset", rd, gold[10'h100]);
    do_acc(1'b0, 24'h000404, 4'hF, 32'h0, m, rd, wbw, scyc);
    check(m == 1'b0, "R2", "neighbour word hits after refill", 32'(m), 32'h0);
    check(rd == 32'hD00DF00D, "R7", "store survived write-back and refill", rd, 32'hD00DF00D);

    // same-index tag coexistence: two tags in one set both hit
    do_acc(1'b0, 24'h000800, 4'hF, 32'h0, m, rd, wbw, scyc);
    do_acc(1'b0, 24'h000404, 4'hF, 32'h0, m, rd, wbw, scyc);
    check(m == 1'b0, "R1", "second tag of set still present", 32'(m), 32'h0);
    do_acc(1'b0, 24'h000808, 4'hF, 32'h0, m, rd, wbw, scyc);
    check(m == 1'b0, "R1", "first tag of set still present", 32'(m), 32'h0);
    check(rd == gold[10'h202], "R1", "data of coexisting tag", rd, gold[10'h202]);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule